// File: doc/BRIEF.md
# ADC Controller Register Front End

This block is the register-side control unit of a successive-approximation ADC controller. Software reaches it over a simple 32-bit word bus with single-cycle write and read strobes. From the values written, it issues start, stop and calibration pulses to a separate conversion engine, which does the timing and averaging. The engine reports each finished sample with a one-cycle done strobe and a result word. The block then stores the sample at the selected resolution and raises a completion flag. That flag, gated by a per-channel enable, drives the interrupt line.

A conversion starts when the channel field of the first channel control word is written with any code except all ones; writing all ones halts the converter. A continuous-run bit in general control restarts the engine after every sample. A self-clearing bit in the same word runs a calibration, whose outcome appears as a failure flag in general status. An overwrite-enable bit in the configuration word decides whether an unread sample may be replaced.

Top module: `adc_ctrl_regs`

## Requirements
- R1: Registers sit at word offsets 0x00 (channel control 0), 0x04 (channel control 1), 0x08 (status), 0x0C (result 0), 0x10 (result 1, reads zero), 0x14 (configuration), 0x18 (general control), 0x1C (general status), 0x20, 0x24, 0x28 and 0x30 (auxiliary words). An access whose address has bits [1:0] nonzero, or that lies above 0x30, or that hits the hole at 0x2C, reads zero and changes nothing.
- R2: A write to offset 0x00 stores bits [4:0] as the channel and bit 7 as interrupt enable. If the channel is not 0x1F, conv_start is high for exactly one cycle, in the cycle after the write, with conv_chan equal to the channel. Bit 0 of general status reads 1 while a conversion is in flight.
- R3: Writing channel 0x1F pulses conv_stop in the cycle after the write and issues no conv_start. A later eng_done is then ignored: the result and the status flag do not change.
- R4: An accepted eng_done loads result 0 with eng_result, right-justified and zero-extended, according to configuration bits [3:2]: 00 keeps 8 bits, 01 keeps 10 bits, and 10 or 11 keep the full 12 bits. In the same clock edge, status bit 0 is set.
- R5: Reading offset 0x0C clears status bit 0. irq is high exactly when status bit 0 and the stored interrupt-enable bit are both 1.
- R6: When configuration bit 16 is 0 and status bit 0 is set, a new eng_done leaves result 0 unchanged. When bit 16 is 1, the new sample replaces the old one.
- R7: When general control bit 6 is 1, every eng_done of an active conversion is followed one cycle later by a conv_start on the same channel. After bit 6 is cleared, the next eng_done ends the run: there is no conv_start, and general status bit 0 reads 0.
- R8: Writing 1 to general control bit 7 pulses cal_start in the next cycle, and bit 7 then reads 1. On cal_done, bit 7 reads 0, general status bit 1 takes the value of cal_fail, and status bit 0 is set, so irq is raised when enabled. Result 0 does not change.
- R9: avg_en follows general control bit 5. avg_sel follows configuration bits [15:14] (00, 01, 10 and 11 select 4, 8, 16 and 32 samples). conv_res follows configuration bits [3:2].
- R10: Configuration reads back bits [16:0] of the written value. Channel control 1 reads back bits [7:0]. The auxiliary words read back bits [15:0]. Writes to status, result 0, result 1 and general status are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe; a read of result 0 clears the flag at the edge |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_rd |
| irq | output | 1 | Completion interrupt |
| conv_start | output | 1 | One-cycle start pulse to the engine |
| conv_stop | output | 1 | One-cycle halt pulse to the engine |
| conv_chan | output | CHAN_W (5) | Selected input channel |
| conv_res | output | 2 | Resolution code |
| avg_en | output | 1 | Hardware averaging enable |
| avg_sel | output | 2 | Averaging depth code |
| eng_done | input | 1 | Engine sample-finished strobe |
| eng_result | input | RES_W (12) | Engine sample value |
| cal_start | output | 1 | One-cycle calibration start pulse |
| cal_done | input | 1 | Calibration finished strobe |
| cal_fail | input | 1 | Calibration outcome, valid with cal_done |

## Verification
The start, stop and calibration pulses come from registers, so they are due in the cycle after the clock edge that captures the write or the done strobe. The bench drives every input at a falling edge and samples the pulses at the next falling edge. Result, status and general status change at the edge that captures eng_done or cal_done, and read data is combinational, so a read issued at the next falling edge returns the new value. A read of result 0 clears the flag at the edge that ends the read, and irq is checked at the falling edge after it. The scoreboard queues the channel expected for each start and pops the queue whenever conv_start is high at a falling edge. An unexpected start and a leftover entry both count as failures.

// File: rtl/adc_regs_pkg.sv
package adc_regs_pkg;

   localparam int NUM_REGS  = 12;
   localparam int AUX_FIRST = 8;
   localparam int NUM_AUX   = 4;

   typedef enum logic [3:0] {
      RI_CHCTL0  = 4'd0,
      RI_CHCTL1  = 4'd1,
      RI_STATUS  = 4'd2,
      RI_RESULT0 = 4'd3,
      RI_RESULT1 = 4'd4,
      RI_CONFIG  = 4'd5,
      RI_GENCTL  = 4'd6,
      RI_GENSTS  = 4'd7,
      RI_CMPVAL  = 4'd8,
      RI_OFFSET  = 4'd9,
      RI_CALVAL  = 4'd10,
      RI_PINCTL  = 4'd11
   } reg_idx_e;

   localparam logic [31:0] LAST_OFFSET = 32'h30;

   // bit positions decoded by software and by the engine
   localparam int CH_IE_BIT   = 7;
   localparam int ST_DONE_BIT = 0;
   localparam int GC_AVG_BIT  = 5;
   localparam int GC_CONT_BIT = 6;
   localparam int GC_CAL_BIT  = 7;
   localparam int GS_BUSY_BIT = 0;
   localparam int GS_CALF_BIT = 1;
   localparam int CF_RES_LO   = 2;
   localparam int CF_AVG_LO   = 14;
   localparam int CF_OVWR_BIT = 16;
   localparam int CF_WIDTH    = 17;

   typedef enum logic [1:0] {
      RES_8    = 2'd0,
      RES_10   = 2'd1,
      RES_12   = 2'd2,
      RES_FULL = 2'd3
   } res_mode_e;

   function automatic logic [31:0] reg_offset(int unsigned idx);
      logic [31:0] off;
      if (idx == 32'd11) off = LAST_OFFSET;
      else               off = 32'(idx * 4);
      return off;
   endfunction

endpackage

// File: rtl/adc_addr_decode.sv
module adc_addr_decode
   import adc_regs_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic                rd,
   input  logic [ADDR_W-1:0]   addr,
   output logic [NUM_REGS-1:0] wr_sel,
   output logic [NUM_REGS-1:0] rd_sel
);

   logic [31:0] addr32;
   logic        aligned;
   logic        in_range;

   always_comb begin
      addr32             = '0;
      addr32[ADDR_W-1:0] = addr;
   end

   assign aligned  = (addr[1:0] == 2'b00);
   assign in_range = (addr32 <= LAST_OFFSET);

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
      logic hit;
      assign hit       = aligned && in_range && (addr32 == reg_offset(g));
      assign wr_sel[g] = wr & hit;
      assign rd_sel[g] = rd & hit;
   end

   a_r1_single_select : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_sel) && $onehot0(rd_sel));

   a_r1_misaligned_none : assert property (@(posedge clk) disable iff (!rst_n)
      (addr[1:0] != 2'b00) |-> (wr_sel == '0 && rd_sel == '0));

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
   import adc_regs_pkg::*;
#(
   parameter int CHAN_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hc0_wr,
   input  logic              gc_wr,
   input  logic [7:0]        wdata,
   input  logic              eng_done,
   input  logic              cal_done,
   input  logic              cal_fail_in,
   output logic              conv_start,
   output logic              conv_stop,
   output logic [CHAN_W-1:0] conv_chan,
   output logic              chan_ie,
   output logic              avg_en,
   output logic              cal_start,
   output logic              done_acc,
   output logic              cal_evt,
   output logic [31:0]       hc0_view,
   output logic [31:0]       gc_view,
   output logic [31:0]       gs_view
);

   localparam logic [CHAN_W-1:0] CHAN_HALT = {CHAN_W{1'b1}};

   logic [CHAN_W-1:0] chan_q;
   logic              ie_q;
   logic [6:0]        gc_q;
   logic              active_q;
   logic              start_q;
   logic              stop_q;
   logic              cal_busy_q;
   logic              cal_start_q;
   logic              cal_fail_q;
   logic              halt_req;
   logic              cont_next;
   logic              restart;

   assign halt_req  = (wdata[CHAN_W-1:0] == CHAN_HALT);
   assign done_acc  = eng_done && active_q;
   assign cont_next = gc_wr ? wdata[GC_CONT_BIT] : gc_q[GC_CONT_BIT];
   assign restart   = done_acc && cont_next && !hc0_wr;
   assign cal_evt   = cal_busy_q && cal_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_q      <= CHAN_HALT;
         ie_q        <= 1'b0;
         gc_q        <= '0;
         active_q    <= 1'b0;
         start_q     <= 1'b0;
         stop_q      <= 1'b0;
         cal_busy_q  <= 1'b0;
         cal_start_q <= 1'b0;
         cal_fail_q  <= 1'b0;
      end else begin
         start_q     <= 1'b0;
         stop_q      <= 1'b0;
         cal_start_q <= 1'b0;
         if (gc_wr) gc_q <= wdata[6:0];
         if (hc0_wr) begin
            chan_q <= wdata[CHAN_W-1:0];
            ie_q   <= wdata[CH_IE_BIT];
            if (halt_req) begin
               active_q <= 1'b0;
               stop_q   <= 1'b1;
            end else begin
               active_q <= 1'b1;
               start_q  <= 1'b1;
            end
         end else if (done_acc) begin
            if (restart) start_q  <= 1'b1;
            else         active_q <= 1'b0;
         end
         if (cal_evt) begin
            cal_busy_q <= 1'b0;
            cal_fail_q <= cal_fail_in;
         end else if (gc_wr && wdata[GC_CAL_BIT] && !cal_busy_q) begin
            cal_busy_q  <= 1'b1;
            cal_start_q <= 1'b1;
            cal_fail_q  <= 1'b0;
         end
      end
   end

   assign conv_start = start_q;
   assign conv_stop  = stop_q;
   assign conv_chan  = chan_q;
   assign chan_ie    = ie_q;
   assign avg_en     = gc_q[GC_AVG_BIT];
   assign cal_start  = cal_start_q;

   always_comb begin
      hc0_view                = '0;
      hc0_view[CHAN_W-1:0]    = chan_q;
      hc0_view[CH_IE_BIT]     = ie_q;
      gc_view                 = '0;
      gc_view[6:0]            = gc_q;
      gc_view[GC_CAL_BIT]     = cal_busy_q;
      gs_view                 = '0;
      gs_view[GS_BUSY_BIT]    = active_q;
      gs_view[GS_CALF_BIT]    = cal_fail_q;
   end

   a_r2_start_real_chan : assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> (conv_chan != CHAN_HALT));

   a_r7_start_only_active : assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> active_q);

   a_r3_stop_idles : assert property (@(posedge clk) disable iff (!rst_n)
      conv_stop |-> (!active_q && !conv_start));

   a_r8_cal_start_busy : assert property (@(posedge clk) disable iff (!rst_n)
      cal_start |-> cal_busy_q);

   a_r8_cal_done_clears : assert property (@(posedge clk) disable iff (!rst_n)
      cal_evt |=> !cal_busy_q);

endmodule

// File: rtl/adc_result_path.sv
module adc_result_path
   import adc_regs_pkg::*;
#(
   parameter int RES_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done_acc,
   input  logic [RES_W-1:0] eng_result,
   input  logic [1:0]       res_mode,
   input  logic             ovwr_en,
   input  logic             rd_clr,
   input  logic             cal_evt,
   output logic [RES_W-1:0] result_q,
   output logic             flag_q
);

   logic [RES_W-1:0] masked;
   logic             accept;

   always_comb begin
      masked = '0;
      case (res_mode)
         RES_8:   masked[7:0] = eng_result[7:0];
         RES_10:  masked[9:0] = eng_result[9:0];
         default: masked      = eng_result;
      endcase
   end

   assign accept = done_acc && (ovwr_en || !flag_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_q <= '0;
         flag_q   <= 1'b0;
      end else begin
         if (accept) result_q <= masked;
         if (accept || cal_evt) flag_q <= 1'b1;
         else if (rd_clr)       flag_q <= 1'b0;
      end
   end

   a_r6_hold_unread : assert property (@(posedge clk) disable iff (!rst_n)
      (done_acc && !ovwr_en && flag_q) |=> $stable(result_q));

   a_r5_read_clears : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !done_acc && !cal_evt) |=> !flag_q);

   a_r4_narrow_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (accept && res_mode == RES_8) |=> (result_q[RES_W-1:8] == '0));

   a_r4_flag_on_done : assert property (@(posedge clk) disable iff (!rst_n)
      done_acc |=> flag_q);

   a_r8_cal_keeps_result : assert property (@(posedge clk) disable iff (!rst_n)
      (cal_evt && !done_acc) |=> $stable(result_q));

endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
   import adc_regs_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int CHAN_W = 5,
   parameter int RES_W  = 12,
   parameter int AUX_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq,
   output logic              conv_start,
   output logic              conv_stop,
   output logic [CHAN_W-1:0] conv_chan,
   output logic [1:0]        conv_res,
   output logic              avg_en,
   output logic [1:0]        avg_sel,
   input  logic              eng_done,
   input  logic [RES_W-1:0]  eng_result,
   output logic              cal_start,
   input  logic              cal_done,
   input  logic              cal_fail
);

   if (ADDR_W < 6 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must lie in 6..32");
   end
   if (CHAN_W < 1 || CHAN_W > 7) begin : g_bad_chan
      $error("CHAN_W must lie in 1..7");
   end
   if (RES_W < 12 || RES_W > 32) begin : g_bad_res
      $error("RES_W must lie in 12..32");
   end
   if (AUX_W < 1 || AUX_W > 32) begin : g_bad_aux
      $error("AUX_W must lie in 1..32");
   end

   logic [NUM_REGS-1:0] wr_sel;
   logic [NUM_REGS-1:0] rd_sel;
   logic [31:0]         reg_view [NUM_REGS];
   logic [7:0]          hc1_q;
   logic [CF_WIDTH-1:0] cfg_q;
   logic                chan_ie;
   logic                done_acc;
   logic                cal_evt;
   logic [RES_W-1:0]    result_q;
   logic                flag_q;
   logic [31:0]         hc0_view;
   logic [31:0]         gc_view;
   logic [31:0]         gs_view;
   logic                unused_ro_wr;
   logic                unused_wdata;

   assign unused_ro_wr = wr_sel[RI_STATUS] | wr_sel[RI_RESULT0] |
                         wr_sel[RI_RESULT1] | wr_sel[RI_GENSTS];
   assign unused_wdata = ^bus_wdata;

   adc_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (bus_wr),
      .rd     (bus_rd),
      .addr   (bus_addr),
      .wr_sel (wr_sel),
      .rd_sel (rd_sel)
   );

   adc_conv_seq #(.CHAN_W(CHAN_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .hc0_wr      (wr_sel[RI_CHCTL0]),
      .gc_wr       (wr_sel[RI_GENCTL]),
      .wdata       (bus_wdata[7:0]),
      .eng_done    (eng_done),
      .cal_done    (cal_done),
      .cal_fail_in (cal_fail),
      .conv_start  (conv_start),
      .conv_stop   (conv_stop),
      .conv_chan   (conv_chan),
      .chan_ie     (chan_ie),
      .avg_en      (avg_en),
      .cal_start   (cal_start),
      .done_acc    (done_acc),
      .cal_evt     (cal_evt),
      .hc0_view    (hc0_view),
      .gc_view     (gc_view),
      .gs_view     (gs_view)
   );

   adc_result_path #(.RES_W(RES_W)) u_result (
      .clk        (clk),
      .rst_n      (rst_n),
      .done_acc   (done_acc),
      .eng_result (eng_result),
      .res_mode   (cfg_q[CF_RES_LO +: 2]),
      .ovwr_en    (cfg_q[CF_OVWR_BIT]),
      .rd_clr     (rd_sel[RI_RESULT0]),
      .cal_evt    (cal_evt),
      .result_q   (result_q),
      .flag_q     (flag_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hc1_q <= '0;
         cfg_q <= '0;
      end else begin
         if (wr_sel[RI_CHCTL1]) hc1_q <= bus_wdata[7:0];
         if (wr_sel[RI_CONFIG]) cfg_q <= bus_wdata[CF_WIDTH-1:0];
      end
   end

   for (genvar g = 0; g < NUM_AUX; g++) begin : g_aux
      logic [AUX_W-1:0] aux_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     aux_q <= '0;
         else if (wr_sel[AUX_FIRST + g]) aux_q <= bus_wdata[AUX_W-1:0];
      end
      assign reg_view[AUX_FIRST + g] = 32'(aux_q);
   end

   assign reg_view[RI_CHCTL0]  = hc0_view;
   assign reg_view[RI_CHCTL1]  = 32'(hc1_q);
   assign reg_view[RI_STATUS]  = 32'(flag_q) << ST_DONE_BIT;
   assign reg_view[RI_RESULT0] = 32'(result_q);
   assign reg_view[RI_RESULT1] = '0;
   assign reg_view[RI_CONFIG]  = 32'(cfg_q);
   assign reg_view[RI_GENCTL]  = gc_view;
   assign reg_view[RI_GENSTS]  = gs_view;

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_sel[i]) bus_rdata = bus_rdata | reg_view[i];
      end
   end

   assign irq     = flag_q & chan_ie;
   assign conv_res = cfg_q[CF_RES_LO +: 2];
   assign avg_sel = cfg_q[CF_AVG_LO +: 2];

   a_r9_avg_follows_write : assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel[RI_GENCTL] |=> (avg_en == $past(bus_wdata[GC_AVG_BIT])));

   a_r10_status_read_only : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel[RI_STATUS] && !done_acc && !cal_evt && !rd_sel[RI_RESULT0])
      |=> $stable(flag_q));

   a_r5_irq_drop_on_read : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel[RI_RESULT0] && !done_acc && !cal_evt) |=> !irq);

endmodule

// File: tb/test_adc_ctrl_regs.sv
module test_adc_ctrl_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;
   logic        conv_start;
   logic        conv_stop;
   logic [4:0]  conv_chan;
   logic [1:0]  conv_res;
   logic        avg_en;
   logic [1:0]  avg_sel;
   logic        eng_done = 1'b0;
   logic [11:0] eng_result = '0;
   logic        cal_start;
   logic        cal_done = 1'b0;
   logic        cal_fail = 1'b0;

   int          checks = 0;
   int          errors = 0;
   bit          finished = 1'b0;
   logic [4:0]  exp_q [$];
   logic [31:0] rv;

   always #10 clk = ~clk;

   adc_ctrl_regs i_adc_ctrl_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_wr     (bus_wr),
      .bus_rd     (bus_rd),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .irq        (irq),
      .conv_start (conv_start),
      .conv_stop  (conv_stop),
      .conv_chan  (conv_chan),
      .conv_res   (conv_res),
      .avg_en     (avg_en),
      .avg_sel    (avg_sel),
      .eng_done   (eng_done),
      .eng_result (eng_result),
      .cal_start  (cal_start),
      .cal_done   (cal_done),
      .cal_fail   (cal_fail)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic read_chk(string req, logic [7:0] a, logic [31:0] exp);
      logic [31:0] d;
      bus_read(a, d);
      chk(req, d, exp);
   endtask

   // driver: queues the channel the monitor must see on conv_start
   task automatic start_conv(logic [4:0] ch, logic ie);
      exp_q.push_back(ch);
      bus_write(8'h00, {24'h0, ie, 2'b00, ch});
   endtask

   task automatic engine_done(logic [11:0] v);
      @(negedge clk);
      eng_done = 1'b1; eng_result = v;
      @(negedge clk);
      eng_done = 1'b0;
   endtask

   task automatic calibrate(logic fail);
      @(negedge clk);
      cal_done = 1'b1; cal_fail = fail;
      @(negedge clk);
      cal_done = 1'b0; cal_fail = 1'b0;
   endtask

   // monitor: every start pulse must match the next queued channel
   always @(negedge clk) begin
      if (rst_n && conv_start) begin
         if (exp_q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R2 unexpected start actual=%h expected=none", conv_chan);
         end else begin
            logic [4:0] e;
            e = exp_q.pop_front();
            chk("R2 start channel", 32'(conv_chan), 32'(e));
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state
      chk("R5 irq after reset", 32'(irq), 0);
      chk("R2 no start after reset", 32'(conv_start), 0);
      read_chk("R4 status after reset", 8'h08, 0);
      read_chk("R8 genctl after reset", 8'h18, 0);

      // R9 / R10 configuration and storage
      bus_write(8'h14, 32'h0001_4004);
      read_chk("R10 config readback", 8'h14, 32'h0001_4004);
      chk("R9 conv_res", 32'(conv_res), 1);
      chk("R9 avg_sel", 32'(avg_sel), 1);
      bus_write(8'h18, 32'h0000_0020);
      chk("R9 avg_en", 32'(avg_en), 1);
      read_chk("R9 genctl readback", 8'h18, 32'h20);
      bus_write(8'h20, 32'hABCD_1234);
      read_chk("R10 aux 0x20", 8'h20, 32'h1234);
      bus_write(8'h30, 32'h0000_5A5A);
      read_chk("R10 aux 0x30", 8'h30, 32'h5A5A);
      bus_write(8'h04, 32'h0000_01FF);
      read_chk("R10 chctl1", 8'h04, 32'hFF);
      bus_write(8'h08, 32'hFFFF_FFFF);
      read_chk("R10 status ignores write", 8'h08, 0);
      bus_write(8'h1C, 32'hFFFF_FFFF);
      read_chk("R10 genstat ignores write", 8'h1C, 0);

      // R1 address filtering
      bus_write(8'h15, 32'h0);
      read_chk("R1 unaligned write ignored", 8'h14, 32'h0001_4004);
      read_chk("R1 unaligned read zero", 8'h15, 0);
      read_chk("R1 above range read zero", 8'h34, 0);
      read_chk("R1 hole read zero", 8'h2C, 0);
      bus_write(8'h01, 32'h3);
      read_chk("R1 unaligned chctl0 write ignored", 8'h00, 32'h1F);

      // R2 start
      start_conv(5'd5, 1'b1);
      read_chk("R2 chctl0 readback", 8'h00, 32'h85);
      read_chk("R2 busy flag", 8'h1C, 32'h1);

      // R4 resolution 10 bits, R5 flag and irq
      engine_done(12'hFFF);
      read_chk("R4 status set", 8'h08, 32'h1);
      chk("R5 irq raised", 32'(irq), 1);
      read_chk("R4 result 10-bit", 8'h0C, 32'h3FF);
      chk("R5 irq cleared by read", 32'(irq), 0);
      read_chk("R5 status cleared by read", 8'h08, 0);
      read_chk("R2 busy dropped", 8'h1C, 0);

      // R6 overwrite disabled
      bus_write(8'h14, 32'h0000_4008);
      start_conv(5'd3, 1'b0);
      engine_done(12'hABC);
      start_conv(5'd3, 1'b0);
      engine_done(12'h123);
      read_chk("R6 flag still set", 8'h08, 32'h1);
      chk("R5 irq masked", 32'(irq), 0);
      read_chk("R6 unread result kept", 8'h0C, 32'hABC);
      // R6 overwrite enabled
      bus_write(8'h14, 32'h0001_4008);
      start_conv(5'd3, 1'b0);
      engine_done(12'h456);
      start_conv(5'd3, 1'b0);
      engine_done(12'h789);
      read_chk("R6 result replaced", 8'h0C, 32'h789);

      // R4 8-bit and 12-bit
      bus_write(8'h14, 32'h0001_0000);
      start_conv(5'd2, 1'b0);
      engine_done(12'hFFF);
      read_chk("R4 result 8-bit", 8'h0C, 32'hFF);
      bus_write(8'h14, 32'h0001_0008);
      start_conv(5'd2, 1'b0);
      engine_done(12'hA5C);
      read_chk("R4 result 12-bit", 8'h0C, 32'hA5C);

      // R3 stop
      bus_write(8'h00, 32'h1F);
      chk("R3 stop pulse", 32'(conv_stop), 1);
      engine_done(12'h777);
      read_chk("R3 flag untouched", 8'h08, 0);
      read_chk("R3 result untouched", 8'h0C, 32'hA5C);
      read_chk("R3 idle", 8'h1C, 0);

      // R7 continuous
      bus_write(8'h18, 32'h40);
      start_conv(5'd7, 1'b0);
      exp_q.push_back(5'd7);
      engine_done(12'h100);
      read_chk("R7 busy in run", 8'h1C, 32'h1);
      exp_q.push_back(5'd7);
      engine_done(12'h200);
      read_chk("R7 busy still", 8'h1C, 32'h1);
      read_chk("R7 latest result", 8'h0C, 32'h200);
      bus_write(8'h18, 32'h0);
      engine_done(12'h300);
      read_chk("R7 run ended", 8'h1C, 0);
      read_chk("R7 last result", 8'h0C, 32'h300);

      // R8 calibration
      bus_write(8'h00, 32'h9F);
      bus_write(8'h18, 32'h80);
      chk("R8 cal start pulse", 32'(cal_start), 1);
      read_chk("R8 cal bit busy", 8'h18, 32'h80);
      read_chk("R8 no fail yet", 8'h1C, 0);
      calibrate(1'b1);
      read_chk("R8 cal bit cleared", 8'h18, 0);
      read_chk("R8 fail flag", 8'h1C, 32'h2);
      read_chk("R8 status set", 8'h08, 32'h1);
      chk("R8 irq on cal", 32'(irq), 1);
      read_chk("R8 result kept", 8'h0C, 32'h300);
      chk("R5 irq cleared", 32'(irq), 0);
      bus_write(8'h18, 32'h80);
      calibrate(1'b0);
      read_chk("R8 pass clears fail", 8'h1C, 0);

      repeat (3) @(negedge clk);
      chk("R2 all starts seen", 32'(exp_q.size()), 0);
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule